// File: doc/BRIEF.md
# Eight-Bit ALU with Status Flags

This block is the purely combinational arithmetic and logic stage of a small accumulator-style 8-bit processor. Each cycle it is given the working register, an operand read from the register file, an 8-bit literal, the present carry flag and a 6-bit operation code together with a destination bit. It returns the 8-bit result, where that result goes (working register or file register), candidate next values for the carry, digit-carry and zero flags, one write enable per flag, and a skip request for the two counting-and-skip operations.

Subtraction is formed as the file operand plus the one's complement of the working register plus one. Because of this, a set carry after a subtract means no borrow occurred. A digit carry is taken from the carry out of bit 3. Each operation updates a fixed subset of the flags, and the enables tell the status storage outside the block which flags to capture. A literal-mode select reuses the same logic for move, OR, AND and XOR with the literal in place of the file operand. The block holds no state.

Top module: `alu8_flags`

## Requirements
- R1: In byte mode `dst_file` equals `dst_bit` (0 = working register, 1 = file register). In literal mode, and for undefined codes, `dst_file` is 0.
- R2: Add (code 000111) gives f + W modulo 256. Carry is the carry out of bit 7 and digit carry is the carry out of bit 3. Carry, digit carry and zero are all enabled.
- R3: Subtract (code 000010) gives f + ~W + 1 modulo 256. Carry is 1 exactly when f >= W. Digit carry is 1 exactly when f[3:0] >= W[3:0]. All three flags are enabled.
- R4: Whenever the zero flag is enabled, `z_next` is 1 exactly when the 8-bit result is zero.
- R5: Clear (000001, result 0), decrement (000011), OR (000100), AND (000101), XOR (000110), move f (001000), complement (001001) and increment (001010) give the expected result and enable only the zero flag.
- R6: Rotate right (001100) gives {c_in, f[7:1]} with carry f[0]. Rotate left (001101) gives {f[6:0], c_in} with carry f[7]. Rotates enable only the carry flag.
- R7: Swap (001110) gives {f[3:0], f[7:4]} and enables no flag.
- R8: Decrement-and-skip (001011) and increment-and-skip (001111) give f-1 and f+1, enable no flag, and raise `skip_req` exactly when the result is zero. `skip_req` is 0 for every other operation.
- R9: Code 000000 (no-op when `dst_bit`=0, move W to f when `dst_bit`=1) gives W as the result and enables no flag.
- R10: With `lit_sel`=1, `op_code[1:0]` selects the literal operation: 00 move (result k, no flags), 01 OR (k|W), 10 AND (k&W), 11 XOR (k^W). OR, AND and XOR enable only zero. `op_code[5:2]` is ignored.
- R11: The byte operation is chosen by `op_code` alone as listed in R2 to R9, independent of `dst_bit`, except for where the result goes.
- R12: In byte mode any code with `op_code[5:4]` not 00 gives W as the result, enables no flag, raises no skip and sets `dst_file` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| w_val | input | 8 | Working register value |
| f_val | input | 8 | File register operand |
| k_val | input | 8 | Literal operand |
| c_in | input | 1 | Present carry flag |
| op_code | input | 6 | Operation code |
| dst_bit | input | 1 | Destination designator of byte operations |
| lit_sel | input | 1 | Selects the literal operations |
| result | output | 8 | Operation result |
| dst_file | output | 1 | 1 = write result to the file register, 0 = to the working register |
| c_next | output | 1 | Next carry value |
| dc_next | output | 1 | Next digit-carry value |
| z_next | output | 1 | Next zero value |
| c_upd | output | 1 | Carry write enable |
| dc_upd | output | 1 | Digit-carry write enable |
| z_upd | output | 1 | Zero write enable |
| skip_req | output | 1 | Skip request from the counting-and-skip operations |

## Verification
The hardest cases to reach are the flag boundaries. These are a zero result that comes with a carry out (add 0x80+0x80, subtract of equal values), a digit carry with no full carry, and the counting-and-skip operations that land exactly on zero. Uniform random operands reach these only rarely. Directed vectors therefore pin them down, and random stimulus is biased toward small operand values and 0x00/0xFF so that the nibble and byte wrap points recur often.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int ALU_DW = 8;

  typedef enum logic [4:0] {
    K_PASSW = 5'd0,  K_CLR  = 5'd1,  K_SUB  = 5'd2,  K_DEC   = 5'd3,
    K_OR    = 5'd4,  K_AND  = 5'd5,  K_XOR  = 5'd6,  K_ADD   = 5'd7,
    K_MOVF  = 5'd8,  K_COM  = 5'd9,  K_INC  = 5'd10, K_DECSK = 5'd11,
    K_RRC   = 5'd12, K_RLC  = 5'd13, K_SWAP = 5'd14, K_INCSK = 5'd15,
    K_MOVK  = 5'd16, K_NONE = 5'd17
  } kind_e;

  function automatic logic [ALU_DW-1:0] nib_swap(input logic [ALU_DW-1:0] v);
    return {v[ALU_DW/2-1:0], v[ALU_DW-1:ALU_DW/2]};
  endfunction

  function automatic logic [ALU_DW-1:0] rot_right(input logic [ALU_DW-1:0] v, input logic ci);
    return {ci, v[ALU_DW-1:1]};
  endfunction

  function automatic logic [ALU_DW-1:0] rot_left(input logic [ALU_DW-1:0] v, input logic ci);
    return {v[ALU_DW-2:0], ci};
  endfunction

  function automatic logic uses_adder(input kind_e k);
    return (k == K_ADD) || (k == K_SUB) || (k == K_INC) || (k == K_DEC) ||
           (k == K_INCSK) || (k == K_DECSK);
  endfunction
endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
  import alu8_pkg::*;
(
  input  logic [5:0] op_code,
  input  logic       dst_bit,
  input  logic       lit_sel,
  output kind_e      kind,
  output logic       use_k,
  output logic       dst_file,
  output logic       c_en,
  output logic       dc_en,
  output logic       z_en,
  output logic       skip_en
);
  always_comb begin
    kind     = K_NONE;
    use_k    = 1'b0;
    dst_file = 1'b0;
    c_en     = 1'b0;
    dc_en    = 1'b0;
    z_en     = 1'b0;
    skip_en  = 1'b0;
    if (lit_sel) begin
      use_k = 1'b1;
      unique case (op_code[1:0])
        2'b00: kind = K_MOVK;
        2'b01: begin kind = K_OR;  z_en = 1'b1; end
        2'b10: begin kind = K_AND; z_en = 1'b1; end
        default: begin kind = K_XOR; z_en = 1'b1; end
      endcase
    end else if (op_code[5:4] == 2'b00) begin
      kind     = kind_e'({1'b0, op_code[3:0]});
      dst_file = dst_bit;
      unique case (op_code[3:0])
        4'd2, 4'd7:           begin c_en = 1'b1; dc_en = 1'b1; z_en = 1'b1; end
        4'd12, 4'd13:         c_en = 1'b1;
        4'd11, 4'd15:         skip_en = 1'b1;
        4'd0, 4'd14:          ;
        default:              z_en = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int DW = alu8_pkg::ALU_DW
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          ci,
  output logic [DW-1:0] sum,
  output logic          co,
  output logic          hco
);
  localparam int HW = DW / 2;
  localparam int UW = DW - HW;

  logic [HW:0] lo;
  logic [UW:0] hi;

  always_comb begin
    lo  = {1'b0, a[HW-1:0]} + {1'b0, b[HW-1:0]} + {{HW{1'b0}}, ci};
    hi  = {1'b0, a[DW-1:HW]} + {1'b0, b[DW-1:HW]} + {{UW{1'b0}}, lo[HW]};
    sum = {hi[UW-1:0], lo[HW-1:0]};
    hco = lo[HW];
    co  = hi[UW];
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int DW = ALU_DW
) (
  input  kind_e         kind,
  input  logic [DW-1:0] opnd,
  input  logic [DW-1:0] w,
  input  logic          ci,
  output logic [DW-1:0] lres,
  output logic          rot_co
);
  always_comb begin
    rot_co = ci;
    unique case (kind)
      K_CLR:   lres = '0;
      K_OR:    lres = opnd | w;
      K_AND:   lres = opnd & w;
      K_XOR:   lres = opnd ^ w;
      K_MOVF,
      K_MOVK:  lres = opnd;
      K_COM:   lres = ~opnd;
      K_RRC:   begin lres = rot_right(opnd, ci); rot_co = opnd[0];    end
      K_RLC:   begin lres = rot_left(opnd, ci);  rot_co = opnd[DW-1]; end
      K_SWAP:  lres = nib_swap(opnd);
      default: lres = w;
    endcase
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
(
  input  logic [7:0] w_val,
  input  logic [7:0] f_val,
  input  logic [7:0] k_val,
  input  logic       c_in,
  input  logic [5:0] op_code,
  input  logic       dst_bit,
  input  logic       lit_sel,
  output logic [7:0] result,
  output logic       dst_file,
  output logic       c_next,
  output logic       dc_next,
  output logic       z_next,
  output logic       c_upd,
  output logic       dc_upd,
  output logic       z_upd,
  output logic       skip_req
);
  localparam int DW = ALU_DW;

  kind_e         kind;
  logic          use_k;
  logic          skip_en;
  logic [DW-1:0] opnd;
  logic [DW-1:0] add_b;
  logic          add_ci;
  logic [DW-1:0] add_sum;
  logic          add_co;
  logic          add_hco;
  logic [DW-1:0] lres;
  logic          rot_co;
  logic          arith_sel;
  logic          rot_sel;

  alu8_decode u_dec (
    .op_code (op_code),
    .dst_bit (dst_bit),
    .lit_sel (lit_sel),
    .kind    (kind),
    .use_k   (use_k),
    .dst_file(dst_file),
    .c_en    (c_upd),
    .dc_en   (dc_upd),
    .z_en    (z_upd),
    .skip_en (skip_en)
  );

  assign opnd = use_k ? k_val : f_val;

  always_comb begin
    add_b  = w_val;
    add_ci = 1'b0;
    unique case (kind)
      K_SUB:          begin add_b = ~w_val; add_ci = 1'b1; end
      K_INC, K_INCSK: begin add_b = '0;     add_ci = 1'b1; end
      K_DEC, K_DECSK: begin add_b = '1;     add_ci = 1'b0; end
      default:        ;
    endcase
  end

  alu8_adder #(.DW(DW)) u_add (
    .a  (opnd),
    .b  (add_b),
    .ci (add_ci),
    .sum(add_sum),
    .co (add_co),
    .hco(add_hco)
  );

  alu8_logic #(.DW(DW)) u_log (
    .kind  (kind),
    .opnd  (opnd),
    .w     (w_val),
    .ci    (c_in),
    .lres  (lres),
    .rot_co(rot_co)
  );

  assign arith_sel = uses_adder(kind);
  assign rot_sel   = (kind == K_RRC) || (kind == K_RLC);
  assign result    = arith_sel ? add_sum : lres;
  assign c_next    = rot_sel ? rot_co : (arith_sel ? add_co : c_in);
  assign dc_next   = arith_sel ? add_hco : 1'b0;
  assign z_next    = (result == '0);
  assign skip_req  = skip_en && (result == '0);
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk (
  input logic [7:0] result,
  input logic       lit_sel,
  input logic       dst_file,
  input logic       c_next,
  input logic       z_next,
  input logic       c_upd,
  input logic       dc_upd,
  input logic       z_upd,
  input logic       skip_req,
  input logic       rot_sel,
  input logic       add_co
);
  always_comb begin
    // R4
    if (z_upd) zero_flag_chk: assert (z_next == (result == 8'h00));
    // R8
    if (skip_req) skip_quiet_chk: assert ((result == 8'h00) && !c_upd && !dc_upd && !z_upd);
    // R6
    if (rot_sel) rot_carry_only_chk: assert (c_upd && !dc_upd && !z_upd);
    // R2
    if (dc_upd) arith_all_flags_chk: assert (c_upd && z_upd && (c_next == add_co));
    // R1
    if (lit_sel) lit_to_w_chk: assert (!dst_file);
  end
endmodule

bind alu8_flags alu8_flags_chk u_chk (
  .result  (result),
  .lit_sel (lit_sel),
  .dst_file(dst_file),
  .c_next  (c_next),
  .z_next  (z_next),
  .c_upd   (c_upd),
  .dc_upd  (dc_upd),
  .z_upd   (z_upd),
  .skip_req(skip_req),
  .rot_sel (rot_sel),
  .add_co  (add_co)
);

// File: tb/alu8_flags_bench.sv
module alu8_flags_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [7:0] w_val, f_val, k_val, result;
  logic       c_in, dst_bit, lit_sel;
  logic [5:0] op_code;
  logic dst_file, c_next, dc_next, z_next, c_upd, dc_upd, z_upd, skip_req;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  alu8_flags u_alu8_flags (
    .w_val(w_val), .f_val(f_val), .k_val(k_val), .c_in(c_in),
    .op_code(op_code), .dst_bit(dst_bit), .lit_sel(lit_sel),
    .result(result), .dst_file(dst_file), .c_next(c_next), .dc_next(dc_next),
    .z_next(z_next), .c_upd(c_upd), .dc_upd(dc_upd), .z_upd(z_upd),
    .skip_req(skip_req)
  );

  typedef struct packed {
    logic [7:0] r;
    logic tf, c, dc, z, cu, du, zu, sk;
  } exp_t;

  function automatic exp_t model(input logic [7:0] w, f, k, input logic c,
                                 input logic [5:0] op, input logic d, lit);
    exp_t e;
    int fi = f;
    int wi = w;
    e = '0;
    if (lit) begin
      case (op[1:0])
        2'd0: e.r = k;
        2'd1: begin e.r = k | w; e.zu = 1; end
        2'd2: begin e.r = k & w; e.zu = 1; end
        default: begin e.r = k ^ w; e.zu = 1; end
      endcase
    end else if (op > 6'd15) begin
      e.r = w;
    end else begin
      e.tf = d;
      case (op[3:0])
        4'd0:  e.r = w;
        4'd1:  begin e.r = 8'h00; e.zu = 1; end
        4'd2:  begin e.r = 8'((fi - wi) & 255); e.c = (fi >= wi);
                     e.dc = ((fi % 16) >= (wi % 16)); e.cu = 1; e.du = 1; e.zu = 1; end
        4'd3:  begin e.r = 8'((fi + 255) % 256); e.zu = 1; end
        4'd4:  begin e.r = f | w; e.zu = 1; end
        4'd5:  begin e.r = f & w; e.zu = 1; end
        4'd6:  begin e.r = f ^ w; e.zu = 1; end
        4'd7:  begin e.r = 8'((fi + wi) % 256); e.c = (fi + wi) > 255;
                     e.dc = ((fi % 16) + (wi % 16)) > 15; e.cu = 1; e.du = 1; e.zu = 1; end
        4'd8:  begin e.r = f; e.zu = 1; end
        4'd9:  begin e.r = 8'(255 - fi); e.zu = 1; end
        4'd10: begin e.r = 8'((fi + 1) % 256); e.zu = 1; end
        4'd11: begin e.r = 8'((fi + 255) % 256); e.sk = (fi == 1); end
        4'd12: begin e.r = 8'((fi / 2) + (c ? 128 : 0)); e.c = (fi % 2) == 1; e.cu = 1; end
        4'd13: begin e.r = 8'(((fi * 2) % 256) + (c ? 1 : 0)); e.c = fi >= 128; e.cu = 1; end
        4'd14: begin e.r = 8'(((fi % 16) * 16) + (fi / 16)); end
        default: begin e.r = 8'((fi + 1) % 256); e.sk = (fi == 255); end
      endcase
    end
    e.z = (e.r == 8'h00);
    return e;
  endfunction

  function automatic string tag_of(input logic [5:0] op, input logic lit);
    if (lit) return "R10";
    if (op > 6'd15) return "R12";
    case (op[3:0])
      4'd0: return "R9";
      4'd2: return "R3";
      4'd7: return "R2";
      4'd11, 4'd15: return "R8";
      4'd12, 4'd13: return "R6";
      4'd14: return "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic apply(input logic [7:0] w, f, k, input logic c,
                       input logic [5:0] op, input logic d, lit, input string tag);
    exp_t e;
    exp_t g;
    bit bad;
    @(negedge clk);
    w_val = w; f_val = f; k_val = k; c_in = c; op_code = op; dst_bit = d; lit_sel = lit;
    #1;
    e = model(w, f, k, c, op, d, lit);
    g = '{r: result, tf: dst_file, c: c_next, dc: dc_next, z: z_next,
          cu: c_upd, du: dc_upd, zu: z_upd, sk: skip_req};
    bad = (g.r != e.r) || (g.tf != e.tf) || (g.cu != e.cu) || (g.du != e.du) ||
          (g.zu != e.zu) || (g.sk != e.sk) || (e.cu && g.c != e.c) ||
          (e.du && g.dc != e.dc) || (e.zu && g.z != e.z);
    n_chk++;
    if (bad) begin
      n_fail++;
      $display("FAIL %s op=%0d lit=%0b d=%0b w=%h f=%h k=%h c=%0b: got %h expected %h",
               tag, op, lit, d, w, f, k, c, g, e);
    end
  endtask

  function automatic logic [7:0] pick8();
    case ($urandom % 4)
      0: return 8'($urandom % 4);
      1: return 8'(255 - ($urandom % 4));
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    w_val = 0; f_val = 0; k_val = 0; c_in = 0; op_code = 0; dst_bit = 0; lit_sel = 0;
    void'($urandom(32'd1654));
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset-state inputs: no-op with zero operands (R9)
    apply(8'h00, 8'h00, 8'h00, 1'b0, 6'd0, 1'b0, 1'b0, "R9");
    apply(8'h5A, 8'h11, 8'h00, 1'b1, 6'd0, 1'b1, 1'b0, "R9");
    // destination routing (R1)
    apply(8'h33, 8'h44, 8'h00, 1'b0, 6'd4, 1'b1, 1'b0, "R1");
    apply(8'h33, 8'h44, 8'h77, 1'b0, 6'd1, 1'b1, 1'b1, "R1");
    // add corners (R2, R4)
    apply(8'h80, 8'h80, 8'h00, 1'b0, 6'd7, 1'b0, 1'b0, "R2");
    apply(8'h01, 8'h0F, 8'h00, 1'b0, 6'd7, 1'b0, 1'b0, "R2");
    apply(8'h00, 8'h00, 8'h00, 1'b1, 6'd7, 1'b1, 1'b0, "R4");
    // subtract corners (R3)
    apply(8'h42, 8'h42, 8'h00, 1'b0, 6'd2, 1'b0, 1'b0, "R3");
    apply(8'h01, 8'h00, 8'h00, 1'b0, 6'd2, 1'b0, 1'b0, "R3");
    apply(8'h0F, 8'h10, 8'h00, 1'b0, 6'd2, 1'b1, 1'b0, "R3");
    // clear, complement to zero (R5)
    apply(8'hAA, 8'hBB, 8'h00, 1'b0, 6'd1, 1'b0, 1'b0, "R5");
    apply(8'h00, 8'hFF, 8'h00, 1'b0, 6'd9, 1'b1, 1'b0, "R5");
    // rotates (R6)
    apply(8'h00, 8'h01, 8'h00, 1'b0, 6'd12, 1'b0, 1'b0, "R6");
    apply(8'h00, 8'h80, 8'h00, 1'b1, 6'd13, 1'b0, 1'b0, "R6");
    apply(8'h00, 8'h80, 8'h00, 1'b0, 6'd13, 1'b1, 1'b0, "R6");
    // swap (R7)
    apply(8'h00, 8'hC3, 8'h00, 1'b1, 6'd14, 1'b1, 1'b0, "R7");
    // skips (R8)
    apply(8'h00, 8'h01, 8'h00, 1'b0, 6'd11, 1'b1, 1'b0, "R8");
    apply(8'h00, 8'hFF, 8'h00, 1'b0, 6'd15, 1'b1, 1'b0, "R8");
    apply(8'h00, 8'h00, 8'h00, 1'b0, 6'd11, 1'b0, 1'b0, "R8");
    apply(8'h00, 8'hFF, 8'h00, 1'b0, 6'd10, 1'b0, 1'b0, "R8");
    // literal forms, upper code bits ignored (R10)
    apply(8'hF0, 8'h00, 8'h00, 1'b0, 6'b111100, 1'b1, 1'b1, "R10");
    apply(8'hF0, 8'h00, 8'h0F, 1'b0, 6'b000010, 1'b0, 1'b1, "R10");
    apply(8'h3C, 8'h00, 8'h3C, 1'b0, 6'b101011, 1'b0, 1'b1, "R10");
    // code alone picks the operation (R11)
    for (int op = 0; op < 16; op++) begin
      apply(8'h96, 8'h69, 8'h00, 1'b1, 6'(op), 1'b0, 1'b0, "R11");
      apply(8'h96, 8'h69, 8'h00, 1'b1, 6'(op), 1'b1, 1'b0, "R11");
    end
    // undefined codes (R12)
    apply(8'h12, 8'h34, 8'h00, 1'b1, 6'd16, 1'b1, 1'b0, "R12");
    apply(8'h12, 8'h34, 8'h00, 1'b1, 6'd63, 1'b1, 1'b0, "R12");
    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic [5:0] op;
      logic       lit;
      op  = ($urandom % 8 == 0) ? 6'($urandom) : 6'($urandom % 16);
      lit = ($urandom % 5 == 0);
      apply(pick8(), pick8(), pick8(), 1'($urandom), op, 1'($urandom), lit, tag_of(op, lit));
    end
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule